// File: doc/BRIEF.md
# Host Command Frame Decoder

This block sits behind a byte-wide Ethernet receive path and picks control frames sent by a host out of the incoming traffic. It checks each frame's destination address and its EtherType. It then reads the 16-bit command word and signals the command to the transmit side. That side uses the signals to begin sending, to retire one buffered packet, or to halt.

The decoder decides only once the final byte of a frame has arrived. It does not store payload. It keeps a small set of header registers, a byte counter and two address-match flags. A frame is accepted when all of the following hold:

- the upstream frame-check flag marks the frame good;
- the frame is long enough;
- the frame is addressed to this station or to broadcast;
- the EtherType is the private value.

An accepted frame raises exactly one single-cycle event. The source address of the last frame that produced an event is kept for replies. A saturating counter records well-formed frames whose command is not recognised.

Top module: `cmd_frame_parser`

## Requirements
- R1: While `rst_n` is low, all event outputs, `ack_set`, `ack_pkt`, `peer_mac` and `err_count` read zero.
- R2: An accepted frame with command bytes 14..15 equal to 16'h0001 raises `evt_start` for exactly one cycle, in the cycle after the clock edge that samples the last byte.
- R3: An accepted frame with command 16'h0003 raises `evt_ack` for one cycle. Bytes 16..17 form a big-endian word. Its low 5 bits appear on `ack_pkt` and its upper 11 bits appear on `ack_set`, both valid while `evt_ack` is high.
- R4: An accepted frame with command 16'h0005 raises `evt_stop` for one cycle.
- R5: A frame whose bytes 12..13 are not 16'hFADE produces no event and leaves `err_count` unchanged.
- R6: A frame is accepted only if bytes 0..5 equal `local_mac` (byte 0 = bits 47:40) or are all 8'hFF. Any other destination produces no event and no count.
- R7: A frame of fewer than `MIN_LEN` (64) valid bytes from start to end marker is dropped. A frame of exactly 64 bytes is accepted.
- R8: If `rx_fcs_ok` is low on the end-of-frame byte, the frame is dropped with no event and no count.
- R9: An accepted frame with any other command raises no event and increments `err_count` by one. The counter saturates at its maximum (15 by default).
- R10: `peer_mac` takes bytes 6..11 of each frame that raises an event, in the same cycle as the event, and otherwise keeps its value.
- R11: Cycles with `rx_valid` low are ignored. So are valid bytes arriving after an end marker and before the next start marker.
- R12: At most one event output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_fcs_ok | input | 1 | Frame check good, sampled with the last byte |
| local_mac | input | 48 | Station address |
| evt_start | output | 1 | Start command pulse |
| evt_ack | output | 1 | Acknowledge command pulse |
| evt_stop | output | 1 | Stop command pulse |
| ack_set | output | 11 | Acknowledged set number |
| ack_pkt | output | 5 | Acknowledged packet index |
| peer_mac | output | 48 | Source address of last event frame |
| err_count | output | 4 | Saturating unknown-command count |

## Verification
The assertions assume that `rx_eof` arrives only on a valid byte. They also assume that `local_mac` stays constant while a frame is being received. The bench meets both assumptions: it drives an end marker only together with a valid byte, and it sets the station address once before reset is released.

The assertions also rely on accepted frames being at least `MIN_LEN` bytes long, so two event pulses can never be adjacent. The stimulus inserts idle cycles and stray bytes between and inside frames. It never drives a start marker in the middle of a frame.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam logic [15:0] CMDP_ETYPE    = 16'hFADE;
  localparam logic [15:0] CMDP_OP_START = 16'h0001;
  localparam logic [15:0] CMDP_OP_ACK   = 16'h0003;
  localparam logic [15:0] CMDP_OP_STOP  = 16'h0005;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_START = 2'd1,
    KIND_ACK   = 2'd2,
    KIND_STOP  = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/cmdp_capture.sv
module cmdp_capture #(
  parameter int MIN_LEN = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [47:0] local_mac,
  output logic        frame_end,
  output logic        len_ok,
  output logic        dst_ok,
  output logic [47:0] src_mac,
  output logic [15:0] etype,
  output logic [15:0] cmd,
  output logic [15:0] seq
);
  localparam int CNT_W = $clog2(MIN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic             in_q, in_d, beat;
  logic             mloc_q, mloc_d, mbc_q, mbc_d;
  logic [47:0]      src_q, src_d;
  logic [15:0]      typ_q, typ_d, cmd_q, cmd_d, seq_q, seq_d;

  assign beat = rx_valid && (rx_sof || in_q);
  assign idx  = rx_sof ? '0 : cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    in_d   = in_q;
    mloc_d = mloc_q;
    mbc_d  = mbc_q;
    src_d  = src_q;
    typ_d  = typ_q;
    cmd_d  = cmd_q;
    seq_d  = seq_q;
    if (beat) begin
      cnt_d = (idx == LAST) ? idx : idx + 1'b1;
      in_d  = !rx_eof;
      if (rx_sof) begin
        mloc_d = 1'b1;
        mbc_d  = 1'b1;
      end
      for (int k = 0; k < 6; k++) begin
        if (idx == CNT_W'(k)) begin
          mloc_d = (rx_sof ? 1'b1 : mloc_q) && (rx_data == local_mac[47-8*k -: 8]);
          mbc_d  = (rx_sof ? 1'b1 : mbc_q) && (rx_data == 8'hFF);
        end
        if (idx == CNT_W'(6 + k)) src_d[47-8*k -: 8] = rx_data;
      end
      if (idx == CNT_W'(12)) typ_d[15:8] = rx_data;
      if (idx == CNT_W'(13)) typ_d[7:0]  = rx_data;
      if (idx == CNT_W'(14)) cmd_d[15:8] = rx_data;
      if (idx == CNT_W'(15)) cmd_d[7:0]  = rx_data;
      if (idx == CNT_W'(16)) seq_d[15:8] = rx_data;
      if (idx == CNT_W'(17)) seq_d[7:0]  = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      in_q   <= 1'b0;
      mloc_q <= 1'b0;
      mbc_q  <= 1'b0;
      src_q  <= '0;
      typ_q  <= '0;
      cmd_q  <= '0;
      seq_q  <= '0;
    end else if (beat) begin
      cnt_q  <= cnt_d;
      in_q   <= in_d;
      mloc_q <= mloc_d;
      mbc_q  <= mbc_d;
      src_q  <= src_d;
      typ_q  <= typ_d;
      cmd_q  <= cmd_d;
      seq_q  <= seq_d;
    end
  end

  assign frame_end = beat && rx_eof;
  assign len_ok    = (idx == LAST);
  assign dst_ok    = mloc_q || mbc_q;
  assign src_mac   = src_q;
  assign etype     = typ_q;
  assign cmd       = cmd_q;
  assign seq       = seq_q;

  // R11: a cycle without a valid byte leaves the byte counter untouched
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> $stable(cnt_q));
endmodule

// File: rtl/cmdp_classify.sv
module cmdp_classify
  import cmdp_pkg::*;
(
  input  logic        frame_end,
  input  logic        len_ok,
  input  logic        dst_ok,
  input  logic        fcs_ok,
  input  logic [15:0] etype,
  input  logic [15:0] cmd,
  output cmd_kind_e   kind,
  output logic        unknown
);
  logic accept;

  assign accept = frame_end && len_ok && dst_ok && fcs_ok && (etype == CMDP_ETYPE);

  always_comb begin
    kind    = KIND_NONE;
    unknown = 1'b0;
    if (accept) begin
      case (cmd)
        CMDP_OP_START: kind = KIND_START;
        CMDP_OP_ACK:   kind = KIND_ACK;
        CMDP_OP_STOP:  kind = KIND_STOP;
        default:       unknown = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cmdp_events.sv
module cmdp_events
  import cmdp_pkg::*;
#(
  parameter int PKT_W = 5,
  parameter int ERR_W = 4,
  localparam int SET_W = 16 - PKT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_kind_e        kind,
  input  logic             unknown,
  input  logic [15:0]      seq,
  input  logic [47:0]      src_mac,
  output logic             evt_start,
  output logic             evt_ack,
  output logic             evt_stop,
  output logic [SET_W-1:0] ack_set,
  output logic [PKT_W-1:0] ack_pkt,
  output logic [47:0]      peer_mac,
  output logic [ERR_W-1:0] err_count
);
  logic             st_q, ak_q, sp_q;
  logic [SET_W-1:0] set_q, set_d;
  logic [PKT_W-1:0] pkt_q, pkt_d;
  logic [47:0]      peer_q, peer_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             any_kind;

  assign any_kind = (kind != KIND_NONE);

  always_comb begin
    set_d  = set_q;
    pkt_d  = pkt_q;
    peer_d = peer_q;
    err_d  = err_q;
    if (kind == KIND_ACK) begin
      set_d = seq[15:PKT_W];
      pkt_d = seq[PKT_W-1:0];
    end
    if (any_kind) peer_d = src_mac;
    if (unknown && (err_q != '1)) err_d = err_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= 1'b0;
      ak_q   <= 1'b0;
      sp_q   <= 1'b0;
      set_q  <= '0;
      pkt_q  <= '0;
      peer_q <= '0;
      err_q  <= '0;
    end else begin
      st_q   <= (kind == KIND_START);
      ak_q   <= (kind == KIND_ACK);
      sp_q   <= (kind == KIND_STOP);
      set_q  <= set_d;
      pkt_q  <= pkt_d;
      peer_q <= peer_d;
      err_q  <= err_d;
    end
  end

  assign evt_start = st_q;
  assign evt_ack   = ak_q;
  assign evt_stop  = sp_q;
  assign ack_set   = set_q;
  assign ack_pkt   = pkt_q;
  assign peer_mac  = peer_q;
  assign err_count = err_q;

  assert_onehot_events_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_q, ak_q, sp_q}));
  // R2: a start pulse lasts a single cycle
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_q |=> !st_q);
  assert_stop_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q |=> !sp_q);
  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ak_q |-> ($stable(set_q) && $stable(pkt_q)));
  assert_err_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_q) |-> (err_q == $past(err_q) + 1'b1));
  assert_peer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q || ak_q || sp_q) |-> $stable(peer_q));
endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
  import cmdp_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int PKT_W   = 5,
  parameter int ERR_W   = 4,
  localparam int SET_W  = 16 - PKT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             rx_fcs_ok,
  input  logic [47:0]      local_mac,
  output logic             evt_start,
  output logic             evt_ack,
  output logic             evt_stop,
  output logic [SET_W-1:0] ack_set,
  output logic [PKT_W-1:0] ack_pkt,
  output logic [47:0]      peer_mac,
  output logic [ERR_W-1:0] err_count
);
  logic        frame_end, len_ok, dst_ok, unknown;
  logic [47:0] src_mac;
  logic [15:0] etype, cmd, seq;
  cmd_kind_e   kind;

  cmdp_capture #(.MIN_LEN(MIN_LEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .local_mac(local_mac),
    .frame_end(frame_end), .len_ok(len_ok), .dst_ok(dst_ok),
    .src_mac(src_mac), .etype(etype), .cmd(cmd), .seq(seq)
  );

  cmdp_classify u_cls (
    .frame_end(frame_end), .len_ok(len_ok), .dst_ok(dst_ok),
    .fcs_ok(rx_fcs_ok), .etype(etype), .cmd(cmd),
    .kind(kind), .unknown(unknown)
  );

  cmdp_events #(.PKT_W(PKT_W), .ERR_W(ERR_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .kind(kind), .unknown(unknown), .seq(seq),
    .src_mac(src_mac), .evt_start(evt_start), .evt_ack(evt_ack),
    .evt_stop(evt_stop), .ack_set(ack_set), .ack_pkt(ack_pkt),
    .peer_mac(peer_mac), .err_count(err_count)
  );

  // R8: every event follows a valid end-of-frame byte flagged good
  assert_event_after_good_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start || evt_ack || evt_stop) |-> $past(rx_valid && rx_eof && rx_fcs_ok));
endmodule

// File: tb/sim_cmd_frame_parser.sv
module sim_cmd_frame_parser;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof, rx_fcs_ok;
  logic [7:0]  rx_data;
  logic [47:0] local_mac;
  logic        evt_start, evt_ack, evt_stop;
  logic [10:0] ack_set;
  logic [4:0]  ack_pkt;
  logic [47:0] peer_mac;
  logic [3:0]  err_count;

  int checks = 0;
  int errors = 0;
  logic [47:0] peer_exp = '0;
  int          err_exp  = 0;

  localparam logic [47:0] MY_MAC = 48'h000A_3501_0203;

  always #2 clk = ~clk;

  cmd_frame_parser u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_fcs_ok(rx_fcs_ok),
    .local_mac(local_mac), .evt_start(evt_start), .evt_ack(evt_ack),
    .evt_stop(evt_stop), .ack_set(ack_set), .ack_pkt(ack_pkt),
    .peer_mac(peer_mac), .err_count(err_count)
  );

  // dsel: 0 local, 1 broadcast, 2 other; exp: 0 none, 1 start, 2 ack, 3 stop
  typedef struct packed {
    logic [1:0]  dsel;
    logic [15:0] etype;
    logic [15:0] cmd;
    logic [15:0] seq;
    logic [7:0]  len;
    logic        fcs;
    logic        gaps;
    logic [1:0]  exp;
    logic        einc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'hFADE, 16'h0001, 16'h0000, 8'd64, 1'b1, 1'b0, 2'd1, 1'b0}, // R2
    '{2'd1, 16'hFADE, 16'h0003, 16'h1234, 8'd70, 1'b1, 1'b0, 2'd2, 1'b0}, // R3 R6
    '{2'd0, 16'hFADE, 16'h0005, 16'h0000, 8'd64, 1'b1, 1'b1, 2'd3, 1'b0}, // R4 R11
    '{2'd0, 16'h0800, 16'h0001, 16'h0000, 8'd64, 1'b1, 1'b0, 2'd0, 1'b0}, // R5
    '{2'd2, 16'hFADE, 16'h0001, 16'h0000, 8'd64, 1'b1, 1'b0, 2'd0, 1'b0}, // R6
    '{2'd0, 16'hFADE, 16'h0001, 16'h0000, 8'd63, 1'b1, 1'b0, 2'd0, 1'b0}, // R7
    '{2'd0, 16'hFADE, 16'h0003, 16'h0042, 8'd64, 1'b0, 1'b0, 2'd0, 1'b0}, // R8
    '{2'd0, 16'hFADE, 16'h0007, 16'h0000, 8'd64, 1'b1, 1'b0, 2'd0, 1'b1}, // R9
    '{2'd0, 16'hFADE, 16'h0003, 16'hFFFF, 8'd64, 1'b1, 1'b1, 2'd2, 1'b0}, // R3 R11
    '{2'd1, 16'hFADE, 16'h0000, 16'h0000, 8'd80, 1'b0, 1'b0, 2'd0, 1'b0}  // R8
  };

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input vec_t v, input int vi, input int i);
    logic [47:0] dst;
    logic [47:0] src;
    dst = (v.dsel == 2'd1) ? 48'hFFFF_FFFF_FFFF :
          (v.dsel == 2'd2) ? (MY_MAC ^ 48'h1) : MY_MAC;
    src = 48'h0211_2233_4400 | 48'(vi);
    if (i < 6)        return dst[47-8*i -: 8];
    else if (i < 12)  return src[47-8*(i-6) -: 8];
    else if (i == 12) return v.etype[15:8];
    else if (i == 13) return v.etype[7:0];
    else if (i == 14) return v.cmd[15:8];
    else if (i == 15) return v.cmd[7:0];
    else if (i == 16) return v.seq[15:8];
    else if (i == 17) return v.seq[7:0];
    else              return 8'(i);
  endfunction

  task automatic idle();
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h55; rx_fcs_ok = 1'b0;
  endtask

  task automatic send_check(input vec_t v, input int vi);
    if (v.gaps) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hAA; rx_sof = 1'b0; rx_eof = 1'b0; // stray byte, R11
    end
    for (int i = 0; i < int'(v.len); i++) begin
      if (v.gaps && (i % 2 == 1)) begin
        @(negedge clk);
        idle();
      end
      @(negedge clk);
      rx_valid  = 1'b1;
      rx_data   = fbyte(v, vi, i);
      rx_sof    = (i == 0);
      rx_eof    = (i == int'(v.len) - 1);
      rx_fcs_ok = v.fcs;
    end
    @(negedge clk);
    idle();
    if (v.exp != 2'd0) peer_exp = 48'h0211_2233_4400 | 48'(vi);
    if (v.einc && err_exp < 15) err_exp++;
    chk(evt_start == (v.exp == 2'd1), $sformatf("R2 start vec%0d", vi), 64'(evt_start), 64'(v.exp == 2'd1));
    chk(evt_ack   == (v.exp == 2'd2), $sformatf("R3 ack vec%0d", vi),   64'(evt_ack),   64'(v.exp == 2'd2));
    chk(evt_stop  == (v.exp == 2'd3), $sformatf("R4 stop vec%0d", vi),  64'(evt_stop),  64'(v.exp == 2'd3));
    if (v.exp == 2'd2) begin
      chk(ack_set == v.seq[15:5], $sformatf("R3 set vec%0d", vi), 64'(ack_set), 64'(v.seq[15:5]));
      chk(ack_pkt == v.seq[4:0],  $sformatf("R3 pkt vec%0d", vi), 64'(ack_pkt), 64'(v.seq[4:0]));
    end
    chk(peer_mac == peer_exp, $sformatf("R10 peer vec%0d", vi), 64'(peer_mac), 64'(peer_exp));
    chk(int'(err_count) == err_exp, $sformatf("R9 err vec%0d", vi), 64'(err_count), 64'(err_exp));
    @(negedge clk);
    chk({evt_start, evt_ack, evt_stop} == 3'b000, $sformatf("R12 pulse end vec%0d", vi),
        64'({evt_start, evt_ack, evt_stop}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t unk;
    local_mac = MY_MAC;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({evt_start, evt_ack, evt_stop, ack_set, ack_pkt, err_count} == '0 && peer_mac == '0,
        "R1 reset state", 64'(err_count), 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) send_check(VEC[k], k);

    // R9 saturation: seventeen more unknown-command frames
    unk = '{2'd0, 16'hFADE, 16'h00FF, 16'h0000, 8'd64, 1'b1, 1'b0, 2'd0, 1'b1};
    for (int k = 0; k < 17; k++) send_check(unk, 20 + k);
    chk(err_count == 4'hF, "R9 saturated", 64'(err_count), 64'hF);

    // R1: reset asserted mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(err_count == '0 && peer_mac == '0 && ack_set == '0 && ack_pkt == '0,
        "R1 reset clears", 64'(peer_mac), 64'd0);
    rst_n = 1'b1;
    peer_exp = '0;
    err_exp  = 0;
    send_check(VEC[0], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule